// File: doc/BRIEF.md
# Multi-Block Erase Queue

This block takes the block-erase confirm writes that follow a valid erase setup sequence and gathers the addressed blocks into a selection bitmap. The first confirm must arrive while an upstream command decoder reports the unlock and setup cycles as valid. Later confirms are accepted on their own, without unlock cycles, for as long as an acceptance window is open. Every confirm restarts that window. When the window runs out without a new confirm, the queue erases the selected blocks one at a time, starting with the lowest block number. For each block it first runs a timed pre-program phase, which drives the cells to 00h. It then runs a timed erase phase, which drives them to FFh.

While the queue is erasing, it acts only on the suspend and reset command codes. A suspend freezes the current phase, and a later confirm code resumes it at the same point. A per-block failure input is sampled when a block's erase phase ends. A failing block is marked in a failure bitmap, and processing moves on to the rest of the selection. If any block failed, the queue holds a failure state until a reset command clears it. Status logic can read the window flag, the busy and phase flags, the failure bitmap and the current block number directly.

Top module: `blk_erase_queue`

## Requirements
- R1: In idle, a write of 30h while `unlock_ok` is high sets the selection bitmap to the single block given by `wr_addr[ADDR_W-1:BLK_LSB]`, clears the failure bitmap, and opens the window. A 30h write while `unlock_ok` is low is ignored.
- R2: While the window is open, every 30h write adds its block to the selection bitmap, whatever the level of `unlock_ok`.
- R3: `timer_run` is high for exactly TMO_CYC cycles after the most recent confirm. A confirm inside the window restarts the count.
- R4: When the window expires, `busy` rises and the selected blocks are processed in ascending block order. `cur_blk` names the block being processed.
- R5: Each block spends PRG_CYC cycles with `busy` high and `phase_erase` low (pre-program), then ERS_CYC cycles with `phase_erase` high (erase). A block's bit leaves `sel_map` when its erase phase ends.
- R6: While `busy` is high and the queue is not suspended, writes other than B0h (suspend) and F0h (reset) have no effect on any output, and the selection bitmap never grows.
- R7: A B0h write during a phase sets `suspended` and freezes the phase progress, `cur_blk` and `phase_erase`. A 30h write while suspended resumes the same phase.
- R8: An F0h write while the window is open, while a phase is running or while suspended returns the queue to idle with an empty selection.
- R9: When a block's erase phase ends, its `fail_inj` bit is recorded in `fail_map`, and the remaining selected blocks are still processed.
- R10: After the last block, the queue returns to idle if `fail_map` is empty. Otherwise it raises `fail_hold` until an F0h write, which also clears `fail_map`.
- R11: After reset, all flags are low and both bitmaps are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Command write strobe, one cycle |
| wr_addr | input | ADDR_W | Write address; the block number is in bits ADDR_W-1:BLK_LSB |
| wr_data | input | 8 | Command code: 30h confirm/resume, B0h suspend, F0h reset |
| unlock_ok | input | 1 | The decoder's report that the unlock and setup cycles before this write were valid |
| fail_inj | input | NBLK | Per-block failure, sampled at the end of that block's erase phase |
| timer_run | output | 1 | Acceptance window is running |
| busy | output | 1 | Erase sequence is running or suspended |
| phase_erase | output | 1 | Current block is in its erase phase, not its pre-program phase |
| suspended | output | 1 | Sequence is suspended |
| fail_hold | output | 1 | Sequence ended with at least one failure and waits for a reset |
| cur_blk | output | BLK_W | Block being processed |
| sel_map | output | NBLK | Blocks still waiting to be erased |
| fail_map | output | NBLK | Blocks that failed |

## Verification
The assertions are checked on every cycle. They cover four rules: the block under `cur_blk` is always selected while busy, the selection never grows during execution, a failure bit appears only as an erase phase ends, and a held failure always has a nonzero map. Inside the counters, they also check that a frozen count stays frozen and that nothing counts below one. The ascending processing order, the exact window and phase lengths, the window restart on a confirm, and the effect of suspend, resume and reset at different points can only be shown by the bench scenarios. In those scenarios, a cycle-level reference model is compared with the outputs on every clock.

// File: rtl/beq_pkg.sv
package beq_pkg;
   typedef enum logic [2:0] {
      Q_IDLE, Q_WIN, Q_PREP, Q_ERASE, Q_SUSP, Q_FAIL
   } beq_state_e;

   localparam logic [7:0] CODE_CONF = 8'h30;
   localparam logic [7:0] CODE_SUSP = 8'hB0;
   localparam logic [7:0] CODE_RST  = 8'hF0;
endpackage

// File: rtl/beq_count.sv
module beq_count #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] val,
   input  logic         dec,
   output logic [W-1:0] cnt,
   output logic         last
);
   generate
      if (W < 1) begin : g_bad_w
         $error("beq_count: W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (load) cnt <= val;
      else if (dec)  cnt <= cnt - W'(1);
   end

   assign last = (cnt == W'(1));

   // R7: with neither load nor decrement the count is frozen
   a_r7_count_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !dec) |=> $stable(cnt));
   // R3: counting never goes below one
   a_r3_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      dec |-> (cnt > W'(1)));
endmodule

// File: rtl/beq_lowest.sv
module beq_lowest #(
   parameter int N = 128,
   parameter int W = 7
) (
   input  logic [N-1:0] vec,
   output logic [W-1:0] idx,
   output logic         any
);
   generate
      if ((1 << W) < N) begin : g_bad_w
         $error("beq_lowest: W too narrow for N");
      end
   endgenerate

   always_comb begin
      idx = '0;
      any = 1'b0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec[i]) begin
            idx = W'(i);
            any = 1'b1;
         end
      end
   end
endmodule

// File: rtl/blk_erase_queue.sv
module blk_erase_queue
   import beq_pkg::*;
#(
   parameter int ADDR_W  = 19,
   parameter int BLK_LSB = 12,
   parameter int TMO_CYC = 64,
   parameter int PRG_CYC = 16,
   parameter int ERS_CYC = 32,
   localparam int BLK_W  = ADDR_W - BLK_LSB,
   localparam int NBLK   = 1 << BLK_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   input  logic              unlock_ok,
   input  logic [NBLK-1:0]   fail_inj,
   output logic              timer_run,
   output logic              busy,
   output logic              phase_erase,
   output logic              suspended,
   output logic              fail_hold,
   output logic [BLK_W-1:0]  cur_blk,
   output logic [NBLK-1:0]   sel_map,
   output logic [NBLK-1:0]   fail_map
);
   localparam int TW   = $clog2(TMO_CYC + 1);
   localparam int PMAX = (PRG_CYC > ERS_CYC) ? PRG_CYC : ERS_CYC;
   localparam int PW   = $clog2(PMAX + 1);

   generate
      if (BLK_LSB < 0 || BLK_W < 1 || BLK_W > 10) begin : g_bad_addr
         $error("blk_erase_queue: block field must be 1..10 bits");
      end
      if (TMO_CYC < 1 || PRG_CYC < 1 || ERS_CYC < 1) begin : g_bad_len
         $error("blk_erase_queue: window and phase lengths must be >= 1");
      end
   endgenerate

   beq_state_e       st;
   logic             res_erase;
   logic [BLK_W-1:0] blk_num;
   logic [NBLK-1:0]  blk_oh, cur_oh, scan_vec, done_fail;
   logic             cf, sp, rs;
   logic             tmo_load, tmo_dec, tmo_last;
   logic [TW-1:0]    tmo_cnt;
   logic             ph_act, ph_load, ph_dec, ph_last;
   logic [PW-1:0]    ph_cnt, ph_val;
   logic [BLK_W-1:0] scan_idx;
   logic             scan_any;

   assign blk_num = wr_addr[ADDR_W-1:BLK_LSB];
   assign blk_oh  = NBLK'(1) << blk_num;
   assign cur_oh  = NBLK'(1) << cur_blk;
   assign cf = wr_en && (wr_data == CODE_CONF);
   assign sp = wr_en && (wr_data == CODE_SUSP);
   assign rs = wr_en && (wr_data == CODE_RST);

   // acceptance window
   assign tmo_load = (st == Q_IDLE && cf && unlock_ok) || (st == Q_WIN && cf);
   assign tmo_dec  = (st == Q_WIN) && !rs && !cf && !tmo_last;

   beq_count #(.W(TW)) u_tmo (
      .clk(clk), .rst_n(rst_n), .load(tmo_load), .val(TW'(TMO_CYC)),
      .dec(tmo_dec), .cnt(tmo_cnt), .last(tmo_last)
   );

   // phase timer
   assign ph_act  = (st == Q_PREP || st == Q_ERASE) && !rs && !sp;
   assign ph_load = (st == Q_WIN && !rs && !cf && tmo_last) || (ph_act && ph_last);
   assign ph_dec  = ph_act && !ph_last;
   assign ph_val  = (st == Q_PREP) ? PW'(ERS_CYC) : PW'(PRG_CYC);

   beq_count #(.W(PW)) u_phase (
      .clk(clk), .rst_n(rst_n), .load(ph_load), .val(ph_val),
      .dec(ph_dec), .cnt(ph_cnt), .last(ph_last)
   );

   // next block to process
   assign scan_vec = (st == Q_WIN) ? sel_map : (sel_map & ~cur_oh);

   beq_lowest #(.N(NBLK), .W(BLK_W)) u_scan (
      .vec(scan_vec), .idx(scan_idx), .any(scan_any)
   );

   assign done_fail = fail_map | (cur_oh & fail_inj);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= Q_IDLE;
         sel_map   <= '0;
         fail_map  <= '0;
         cur_blk   <= '0;
         res_erase <= 1'b0;
      end else begin
         unique case (st)
            Q_IDLE: if (cf && unlock_ok) begin
               st       <= Q_WIN;
               sel_map  <= blk_oh;
               fail_map <= '0;
            end
            Q_WIN: begin
               if (rs) begin
                  st      <= Q_IDLE;
                  sel_map <= '0;
               end else if (cf) begin
                  sel_map <= sel_map | blk_oh;
               end else if (tmo_last) begin
                  st      <= Q_PREP;
                  cur_blk <= scan_idx;
               end
            end
            Q_PREP: begin
               if (rs) begin
                  st      <= Q_IDLE;
                  sel_map <= '0;
               end else if (sp) begin
                  st        <= Q_SUSP;
                  res_erase <= 1'b0;
               end else if (ph_last) begin
                  st <= Q_ERASE;
               end
            end
            Q_ERASE: begin
               if (rs) begin
                  st      <= Q_IDLE;
                  sel_map <= '0;
               end else if (sp) begin
                  st        <= Q_SUSP;
                  res_erase <= 1'b1;
               end else if (ph_last) begin
                  fail_map <= done_fail;
                  sel_map  <= sel_map & ~cur_oh;
                  if (scan_any) begin
                     cur_blk <= scan_idx;
                     st      <= Q_PREP;
                  end else begin
                     st <= (done_fail != '0) ? Q_FAIL : Q_IDLE;
                  end
               end
            end
            Q_SUSP: begin
               if (rs) begin
                  st      <= Q_IDLE;
                  sel_map <= '0;
               end else if (cf) begin
                  st <= res_erase ? Q_ERASE : Q_PREP;
               end
            end
            Q_FAIL: if (rs) begin
               st       <= Q_IDLE;
               fail_map <= '0;
            end
            default: st <= Q_IDLE;
         endcase
      end
   end

   assign timer_run   = (st == Q_WIN);
   assign busy        = (st == Q_PREP) || (st == Q_ERASE) || (st == Q_SUSP);
   assign phase_erase = (st == Q_ERASE) || (st == Q_SUSP && res_erase);
   assign suspended   = (st == Q_SUSP);
   assign fail_hold   = (st == Q_FAIL);

   // R4: the block being processed is always still selected
   a_r4_cur_selected: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> sel_map[cur_blk]);
   // R6: the selection never grows once execution has begun
   a_r6_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ((sel_map & ~$past(sel_map)) == '0));
   // R9: a failure bit can only appear as an erase phase ends
   a_r9_fail_at_end: assert property (@(posedge clk) disable iff (!rst_n)
      ((fail_map & ~$past(fail_map)) != '0) |-> $past(st == Q_ERASE && ph_last));
   // R10: a held failure always carries a nonzero map and is idle
   a_r10_hold_has_fail: assert property (@(posedge clk) disable iff (!rst_n)
      fail_hold |-> (fail_map != '0 && !busy));
endmodule

// File: tb/sim_blk_erase_queue.sv
module sim_blk_erase_queue;
   localparam int CLK_P   = 10;
   localparam int ADDR_W  = 19;
   localparam int BLK_LSB = 12;
   localparam int TMO     = 12;
   localparam int PRG     = 4;
   localparam int ERS     = 6;
   localparam int BW      = ADDR_W - BLK_LSB;
   localparam int NB      = 1 << BW;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic [ADDR_W-1:0] wr_addr = '0;
   logic [7:0]        wr_data = '0;
   logic              unlock_ok = 1'b0;
   logic [NB-1:0]     fail_inj = '0;
   logic              timer_run, busy, phase_erase, suspended, fail_hold;
   logic [BW-1:0]     cur_blk;
   logic [NB-1:0]     sel_map, fail_map;

   int n_run = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   blk_erase_queue #(
      .ADDR_W(ADDR_W), .BLK_LSB(BLK_LSB), .TMO_CYC(TMO),
      .PRG_CYC(PRG), .ERS_CYC(ERS)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .unlock_ok(unlock_ok), .fail_inj(fail_inj),
      .timer_run(timer_run), .busy(busy), .phase_erase(phase_erase),
      .suspended(suspended), .fail_hold(fail_hold), .cur_blk(cur_blk),
      .sel_map(sel_map), .fail_map(fail_map)
   );

   always #(CLK_P / 2) clk = ~clk;

   task automatic chk(input string req, input logic [NB-1:0] act, input logic [NB-1:0] exp);
      n_run++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int lowest(input bit [NB-1:0] v);
      for (int i = 0; i < NB; i++) if (v[i]) return i;
      return 0;
   endfunction

   // behavioural reference: 0 idle 1 window 2 preprog 3 erase 4 suspended 5 failed
   int mst = 0, mcur = 0, mtmo = 0, mph = 0;
   bit mres = 0;
   bit [NB-1:0] msel = '0, mfail = '0;

   always @(posedge clk) begin
      bit cf, sp, rs;
      int b;
      cf = wr_en && wr_data == 8'h30;
      sp = wr_en && wr_data == 8'hB0;
      rs = wr_en && wr_data == 8'hF0;
      b  = int'(wr_addr >> BLK_LSB);
      if (!rst_n) begin
         mst = 0; mcur = 0; msel = '0; mfail = '0; mres = 0;
      end else begin
         case (mst)
            0: if (cf && unlock_ok) begin
               mst = 1; msel = '0; msel[b] = 1; mfail = '0; mtmo = TMO;
            end
            1: if (rs) begin mst = 0; msel = '0; end
               else if (cf) begin msel[b] = 1; mtmo = TMO; end
               else if (mtmo == 1) begin mst = 2; mcur = lowest(msel); mph = PRG; end
               else mtmo--;
            2: if (rs) begin mst = 0; msel = '0; end
               else if (sp) begin mst = 4; mres = 0; end
               else if (mph == 1) begin mst = 3; mph = ERS; end
               else mph--;
            3: if (rs) begin mst = 0; msel = '0; end
               else if (sp) begin mst = 4; mres = 1; end
               else if (mph == 1) begin
                  if (fail_inj[mcur]) mfail[mcur] = 1;
                  msel[mcur] = 0;
                  if (msel != '0) begin mcur = lowest(msel); mst = 2; mph = PRG; end
                  else mst = (mfail != '0) ? 5 : 0;
               end else mph--;
            4: if (rs) begin mst = 0; msel = '0; end
               else if (cf) mst = mres ? 3 : 2;
            5: if (rs) begin mst = 0; mfail = '0; end
            default: mst = 0;
         endcase
      end
      #(CLK_P / 4);
      if (!finished) begin
         chk("R3 model timer_run", NB'(timer_run), NB'(mst == 1));
         chk("R4 model busy", NB'(busy), NB'(mst >= 2 && mst <= 4));
         chk("R4 model cur_blk", NB'(cur_blk), NB'(mcur));
         chk("R5 model phase_erase", NB'(phase_erase), NB'(mst == 3 || (mst == 4 && mres)));
         chk("R7 model suspended", NB'(suspended), NB'(mst == 4));
         chk("R2 model sel_map", sel_map, msel);
         chk("R9 model fail_map", fail_map, mfail);
         chk("R10 model fail_hold", NB'(fail_hold), NB'(mst == 5));
      end
   end

   task automatic wr(input logic [7:0] d, input int blk, input logic unl);
      @(negedge clk);
      wr_en = 1'b1; wr_data = d; unlock_ok = unl;
      wr_addr = ADDR_W'(blk) << BLK_LSB;
      @(negedge clk);
      wr_en = 1'b0; unlock_ok = 1'b0;
   endtask

   task automatic wait_busy(input logic lvl);
      for (int i = 0; i < 2000 && busy !== lvl; i++) @(negedge clk);
   endtask

   function automatic logic [NB-1:0] bit_of(input int b);
      return NB'(1) << b;
   endfunction

   initial begin
      #(CLK_P * 60000);
      if (!finished) begin
         n_run++; n_bad++;
         $display("FAIL watchdog expired, actual=hung expected=done");
         finished = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
         $finish;
      end
   end

   initial begin
      int cnt, last, ord[$];
      logic [BW-1:0] hold_blk;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk("R11 busy", NB'(busy), '0);
      chk("R11 timer_run", NB'(timer_run), '0);
      chk("R11 sel_map", sel_map, '0);
      chk("R11 fail_hold", NB'(fail_hold), '0);

      // R1 confirm without unlock is ignored
      wr(8'h30, 7, 1'b0);
      chk("R1 no unlock sel", sel_map, '0);
      chk("R1 no unlock timer", NB'(timer_run), '0);
      wr(8'h30, 5, 1'b1);
      chk("R1 first confirm sel", sel_map, bit_of(5));
      chk("R1 first confirm timer", NB'(timer_run), NB'(1));

      // R2 further confirms without unlock
      wr(8'h30, 9, 1'b0);
      wr(8'h30, 2, 1'b0);
      chk("R2 accumulated", sel_map, bit_of(2) | bit_of(5) | bit_of(9));

      // R3 restart then measure window
      repeat (5) @(negedge clk);
      fail_inj = bit_of(5);
      wr(8'h30, 5, 1'b0);
      cnt = 0;
      for (int i = 0; i < 100 && timer_run; i++) begin cnt++; @(negedge clk); end
      chk("R3 window length", NB'(cnt), NB'(TMO));

      // R6 ignored writes during execution
      wait_busy(1'b1);
      wr(8'h30, 20, 1'b1);
      chk("R6 confirm ignored", NB'(sel_map[20]), '0);
      wr(8'h90, 3, 1'b0);
      chk("R6 still busy", NB'(busy), NB'(1));
      chk("R6 still first block", NB'(cur_blk), NB'(2));

      // R4 ascending order
      last = -1;
      for (int i = 0; i < 2000 && busy; i++) begin
         if (int'(cur_blk) != last) begin last = int'(cur_blk); ord.push_back(last); end
         @(negedge clk);
      end
      chk("R4 order count", NB'(ord.size()), NB'(3));
      if (ord.size() == 3) begin
         chk("R4 order 0", NB'(ord[0]), NB'(2));
         chk("R4 order 1", NB'(ord[1]), NB'(5));
         chk("R4 order 2", NB'(ord[2]), NB'(9));
      end
      // R9 middle failure recorded, later block still done; R10 hold
      chk("R9 fail_map", fail_map, bit_of(5));
      chk("R9 all processed", sel_map, '0);
      chk("R10 hold", NB'(fail_hold), NB'(1));
      wr(8'h90, 0, 1'b0);
      chk("R10 hold needs reset", NB'(fail_hold), NB'(1));
      wr(8'hF0, 0, 1'b0);
      chk("R10 released", NB'(fail_hold), '0);
      chk("R10 map cleared", fail_map, '0);

      // R7 suspend and resume
      fail_inj = '0;
      wr(8'h30, 127, 1'b1);
      wr(8'h30, 0, 1'b0);
      wait_busy(1'b1);
      repeat (2) @(negedge clk);
      wr(8'hB0, 0, 1'b0);
      chk("R7 suspended", NB'(suspended), NB'(1));
      hold_blk = cur_blk;
      repeat (20) @(negedge clk);
      chk("R7 frozen busy", NB'(busy), NB'(1));
      chk("R7 frozen block", NB'(cur_blk), NB'(hold_blk));
      chk("R7 frozen phase", NB'(phase_erase), '0);
      wr(8'h30, 0, 1'b0);
      chk("R7 resumed", NB'(suspended), '0);
      wait_busy(1'b0);
      chk("R10 clean finish", NB'(fail_hold), '0);
      chk("R10 clean map", fail_map, '0);

      // R5 phase lengths on a single block
      wr(8'h30, 4, 1'b1);
      wait_busy(1'b1);
      cnt = 0;
      for (int i = 0; i < 200 && busy && !phase_erase; i++) begin cnt++; @(negedge clk); end
      chk("R5 preprogram length", NB'(cnt), NB'(PRG));
      cnt = 0;
      for (int i = 0; i < 200 && phase_erase; i++) begin cnt++; @(negedge clk); end
      chk("R5 erase length", NB'(cnt), NB'(ERS));
      chk("R5 done idle", NB'(busy), '0);

      // R8 reset in window and in execution
      wr(8'h30, 3, 1'b1);
      wr(8'hF0, 0, 1'b0);
      chk("R8 window abort timer", NB'(timer_run), '0);
      chk("R8 window abort sel", sel_map, '0);
      wr(8'h30, 6, 1'b1);
      wait_busy(1'b1);
      wr(8'hF0, 0, 1'b0);
      chk("R8 exec abort busy", NB'(busy), '0);
      chk("R8 exec abort sel", sel_map, '0);
      repeat (4) @(negedge clk);

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
   end
endmodule